// File: doc/BRIEF.md
# PLL Divider Register Staging Controller

This block is the register front end of a clock-multiplier PLL. A decoded register bus (write strobe, address, data byte) delivers an input-divider code, a feedback-divider code and a control byte. The block turns the codes into the divide ratios the analog loop uses. The synthesized clock is Fout = Fref × M / (N × P), and it is meant to equal 1024 times the sample rate. For example, a 12.288 MHz reference with N = 3, M = 10 and P = 5 gives 8.192 MHz, which is 1024 × 8 kHz.

The two dividers never reach the loop one at a time. A write of the input-divider code arms a staging flag. The next bus write commits the staged input code and the new feedback code together, provided that write targets the feedback register. Any other next write throws the staged value away. Each register holds the ratio minus one. When a pair commits, a one-cycle retune strobe tells the loop to restart its lock sequence. A bit of the control register picks a divide-by-5 or divide-by-10 stage after the oscillator.

Top module: `pll_stage_top`

## Requirements
- R1: After reset, nRatio = 1, mRatio = 1, postDiv = 5, retune = 0, and reads of addresses 2, 3 and 4 return 0.
- R2: A write to address 3 stores its byte as the staged input code and arms staging. It does not change nRatio, mRatio or retune.
- R3: While staging is armed, the next write to address 4 commits the staged input code and this write's byte as a pair. Idle bus cycles between the two writes do not break the pair. Both ratios change on the same clock edge.
- R4: The output ratios equal the committed codes plus one, as 9-bit values. Code 0 gives ratio 1 and code 255 gives ratio 256.
- R5: The active ratios stay unchanged in two cases: a write to any address other than 3 or 4 while staging is armed, and a write to address 4 while staging is not armed. Either write disarms staging. A further write to address 3 while armed replaces the staged code and keeps staging armed.
- R6: retune is high for exactly one cycle, in the cycle after the committing write. It is low at all other times.
- R7: Bit 0 of the control register at address 2 selects the post-divider: 0 gives postDiv = 5 and 1 gives postDiv = 10. The new value shows in the cycle after the write, and a control write never raises retune.
- R8: rdData returns, combinationally, the last byte written to address 2, 3 or 4. Every other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one bus write per cycle it is high |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Read data for rdAddr |
| nRatio | output | 9 | Active input divide ratio (code + 1) |
| mRatio | output | 9 | Active feedback divide ratio (code + 1) |
| postDiv | output | 4 | Post-divider value, 5 or 10 |
| retune | output | 1 | One-cycle strobe when a new pair commits |

## Verification
The staging logic is driven with several write orders:
- A clean input-then-feedback pair, both back to back and with idle cycles between. This shows that only the next write, not the next cycle, decides.
- A feedback write with nothing staged, and an input write followed by a control write or an unused-address write. These must leave the ratios untouched, which separates a correct pair check from a design that commits on any feedback write.
- Two input writes before the feedback write. This shows which staged code wins.

The extreme codes 0 and 255 expose off-by-one and width errors. A ratio check on the committed pair confirms that the 12.288 MHz, 8 kHz setting produces 1024 × 8 kHz.

// File: rtl/pll_stage_pkg.sv
package pll_stage_pkg;
  typedef struct packed {
    logic loadN;
    logic loadM;
    logic loadCtl;
    logic commit;
  } stageStrobes_t;
endpackage

// File: rtl/pll_stage_ctrl.sv
module pll_stage_ctrl
  import pll_stage_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 2,
  parameter int N_ADDR   = 3,
  parameter int M_ADDR   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output stageStrobes_t     strobes,
  output logic              armed
);
  localparam logic [ADDR_W-1:0] N_SEL   = ADDR_W'(N_ADDR);
  localparam logic [ADDR_W-1:0] M_SEL   = ADDR_W'(M_ADDR);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);

  logic armedQ;
  logic hitN, hitM, hitCtl;

  assign hitN   = wrEn && (wrAddr == N_SEL);
  assign hitM   = wrEn && (wrAddr == M_SEL);
  assign hitCtl = wrEn && (wrAddr == CTL_SEL);

  // Any bus write ends the staging window; only an input-code write opens it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     armedQ <= 1'b0;
    else if (wrEn) armedQ <= hitN;
  end

  always_comb begin
    strobes.loadN   = hitN;
    strobes.loadM   = hitM;
    strobes.loadCtl = hitCtl;
    strobes.commit  = hitM && armedQ;
  end

  assign armed = armedQ;
endmodule

// File: rtl/pll_stage_dp.sv
module pll_stage_dp
  import pll_stage_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CODE_W   = 8,
  parameter int CTL_ADDR = 2,
  parameter int N_ADDR   = 3,
  parameter int M_ADDR   = 4,
  parameter int POST_BIT = 0,
  parameter int POST_LO  = 5,
  parameter int POST_HI  = 10,
  parameter int POST_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobes_t     strobes,
  input  logic [CODE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CODE_W-1:0] rdData,
  output logic [CODE_W:0]   nRatio,
  output logic [CODE_W:0]   mRatio,
  output logic [POST_W-1:0] postDiv,
  output logic              retune
);
  localparam int RATIO_W = CODE_W + 1;
  localparam logic [ADDR_W-1:0] N_SEL   = ADDR_W'(N_ADDR);
  localparam logic [ADDR_W-1:0] M_SEL   = ADDR_W'(M_ADDR);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);

  logic [CODE_W-1:0] nStaged, mWritten, ctlReg;
  logic [CODE_W-1:0] nActive, mActive;
  logic              retuneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nStaged  <= '0;
      mWritten <= '0;
      ctlReg   <= '0;
    end else begin
      if (strobes.loadN)   nStaged  <= wrData;
      if (strobes.loadM)   mWritten <= wrData;
      if (strobes.loadCtl) ctlReg   <= wrData;
    end
  end

  // Both active codes move on the same edge, so the loop never sees a half pair.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nActive <= '0;
      mActive <= '0;
      retuneQ <= 1'b0;
    end else begin
      retuneQ <= strobes.commit;
      if (strobes.commit) begin
        nActive <= nStaged;
        mActive <= wrData;
      end
    end
  end

  assign nRatio  = RATIO_W'(nActive) + RATIO_W'(1);
  assign mRatio  = RATIO_W'(mActive) + RATIO_W'(1);
  assign postDiv = ctlReg[POST_BIT] ? POST_W'(POST_HI) : POST_W'(POST_LO);
  assign retune  = retuneQ;

  always_comb begin
    unique case (rdAddr)
      CTL_SEL: rdData = ctlReg;
      N_SEL:   rdData = nStaged;
      M_SEL:   rdData = mWritten;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pll_stage_top.sv
module pll_stage_top
  import pll_stage_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CODE_W = 8,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CODE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CODE_W-1:0] rdData,
  output logic [CODE_W:0]   nRatio,
  output logic [CODE_W:0]   mRatio,
  output logic [POST_W-1:0] postDiv,
  output logic              retune
);
  stageStrobes_t strobes;
  logic          armed;

  pll_stage_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .strobes(strobes), .armed(armed)
  );

  pll_stage_dp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .POST_W(POST_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .nRatio(nRatio), .mRatio(mRatio),
    .postDiv(postDiv), .retune(retune)
  );
endmodule

// File: rtl/pll_stage_chk.sv
module pll_stage_chk #(
  parameter int ADDR_W = 4,
  parameter int CODE_W = 8,
  parameter int POST_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              armed,
  input logic [CODE_W:0]   nRatio,
  input logic [CODE_W:0]   mRatio,
  input logic [POST_W-1:0] postDiv,
  input logic              retune
);
  p_arm_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(wrEn && wrAddr == ADDR_W'(3)));

  p_pair_commits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wrEn && wrAddr == ADDR_W'(4)) |=> retune);

  p_ratio_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (nRatio != '0) && (mRatio != '0));

  p_hold_without_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    !retune |-> ($stable(nRatio) && $stable(mRatio)));

  p_retune_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    retune |-> $past(armed && wrEn && wrAddr == ADDR_W'(4)));

  p_retune_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    retune |=> !retune);

  p_postdiv_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (postDiv == POST_W'(5)) || (postDiv == POST_W'(10)));
endmodule

bind pll_stage_top pll_stage_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .POST_W(POST_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .armed(armed),
  .nRatio(nRatio), .mRatio(mRatio), .postDiv(postDiv), .retune(retune)
);

// File: tb/test_pll_stage_top.sv
module test_pll_stage_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [8:0] nRatio, mRatio;
  logic [3:0] postDiv;
  logic       retune;

  int total = 0;
  int bad = 0;
  logic sawRetune;
  logic [8:0] expN = 9'd1, expM = 9'd1;

  always #2.5 clk = ~clk;

  pll_stage_top i_pll_stage_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .nRatio(nRatio), .mRatio(mRatio),
    .postDiv(postDiv), .retune(retune)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bus write; sawRetune is retune in the cycle after the write edge.
  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    sawRetune = retune;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic checkRatios(input string req);
    check(req, nRatio, expN);
    check(req, mRatio, expM);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 nRatio", nRatio, 1);
    check("R1 mRatio", mRatio, 1);
    check("R1 postDiv", postDiv, 5);
    check("R1 retune", retune, 0);
    for (int a = 2; a <= 4; a++) begin
      readReg(4'(a), v);
      check("R1 read", v, 0);
    end
  endtask

  task automatic t_ordered_pair;
    busWrite(4'd3, 8'd2);
    check("R2 no retune on N write", sawRetune, 0);
    checkRatios("R2 ratios held");
    busWrite(4'd4, 8'd9);
    expN = 9'd3; expM = 9'd10;
    check("R6 retune after commit", sawRetune, 1);
    checkRatios("R3 pair committed");
    @(negedge clk);
    check("R6 retune one cycle", retune, 0);
    check("R3 ratio relation",
          (64'd12288000 * mRatio) / (nRatio * postDiv), 64'd1024 * 8000);
  endtask

  task automatic t_gap_pair;
    busWrite(4'd3, 8'd6);
    repeat (4) @(negedge clk);
    busWrite(4'd4, 8'd20);
    expN = 9'd7; expM = 9'd21;
    check("R3 idle gap retune", sawRetune, 1);
    checkRatios("R3 idle gap pair");
  endtask

  task automatic t_lone_m;
    busWrite(4'd4, 8'd77);
    check("R5 lone M no retune", sawRetune, 0);
    checkRatios("R5 lone M ratios held");
  endtask

  task automatic t_break_ctl;
    busWrite(4'd3, 8'd40);
    busWrite(4'd2, 8'd0);
    check("R7 ctl no retune", sawRetune, 0);
    busWrite(4'd4, 8'd41);
    check("R5 ctl breaks pair", sawRetune, 0);
    checkRatios("R5 ctl breaks pair ratios");
  endtask

  task automatic t_break_unused;
    logic [7:0] v;
    busWrite(4'd3, 8'd50);
    busWrite(4'd9, 8'hA5);
    readReg(4'd9, v);
    check("R8 unused reads zero", v, 0);
    busWrite(4'd4, 8'd51);
    check("R5 unused breaks pair", sawRetune, 0);
    checkRatios("R5 unused breaks pair ratios");
  endtask

  task automatic t_restage;
    busWrite(4'd3, 8'd11);
    busWrite(4'd3, 8'd12);
    checkRatios("R2 restage held");
    busWrite(4'd4, 8'd13);
    expN = 9'd13; expM = 9'd14;
    check("R5 restage commits", sawRetune, 1);
    checkRatios("R5 latest N wins");
  endtask

  task automatic t_extremes;
    busWrite(4'd3, 8'd255);
    busWrite(4'd4, 8'd255);
    expN = 9'd256; expM = 9'd256;
    checkRatios("R4 max codes");
    busWrite(4'd3, 8'd0);
    busWrite(4'd4, 8'd0);
    expN = 9'd1; expM = 9'd1;
    checkRatios("R4 zero codes");
  endtask

  task automatic t_postdiv;
    busWrite(4'd2, 8'h01);
    check("R7 select div10", postDiv, 10);
    check("R7 no retune", sawRetune, 0);
    checkRatios("R7 ratios held");
    busWrite(4'd2, 8'hFE);
    check("R7 select div5", postDiv, 5);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    busWrite(4'd3, 8'h5C);
    busWrite(4'd4, 8'hC3);
    busWrite(4'd2, 8'h81);
    readReg(4'd3, v); check("R8 read N", v, 8'h5C);
    readReg(4'd4, v); check("R8 read M", v, 8'hC3);
    readReg(4'd2, v); check("R8 read ctl", v, 8'h81);
    readReg(4'd0, v); check("R8 read addr0", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ordered_pair();
    t_gap_pair();
    t_lone_m();
    t_break_ctl();
    t_break_unused();
    t_restage();
    t_extremes();
    t_postdiv();
    t_readback();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule